// File: doc/BRIEF.md
# Burst-Addressed Byte-Write Synchronous SRAM

This block is a single-port synchronous static memory with a word of two bytes and a small burst sequencer in front of it. A cycle is started by one of two address strobes. The processor strobe always begins a read. The controller strobe begins a read or a write, decided by the write enables on the same edge. After a start, the advance input steps through a four-word burst, either in XOR (interleaved) order or in linear wrapping order. A static select input puts the read path in pipelined timing, where data appears one cycle after the access edge, or in flow-through timing, where data appears right after the access edge.

Writes are decoded per byte. A global write enable overrides everything and writes the whole word. Otherwise a byte is written when the byte-write gate and that byte's own enable are both low. Read data leaves on `q_out` together with `q_drive`, which tells the surrounding pad logic when to drive a tri-state bus. The asynchronous output enable gates `q_drive` without waiting for a clock edge. A write cycle and a deselect both turn the bus off.

Top module: `bw_sync_sram`

## Requirements
- R1: With `gw_n` low on an edge where writes are honoured, both bytes of `d_in` are written, whatever `bwe_n` and `bw_n` are.
- R2: With `gw_n` high, byte i (bit i of `bw_n`; byte 0 is `d_in[7:0]`, byte 1 is `d_in[15:8]`) is written only when `bwe_n` and `bw_n[i]` are both low. If no byte is enabled, the cycle is a read.
- R3: On an edge where `adsp_n` is low and `cs0_n` is low, all write enables are ignored and the loaded address is read. Byte enables are honoured on the later edges of that burst.
- R4: On an edge where `adsc_n` is low and the processor strobe is not taking effect, the write enables and `d_in` are sampled on that same edge and applied to the external address.
- R5: With `flow_n` high (pipelined), data read on edge t is first driven after edge t+1.
- R6: With `flow_n` low (flow-through), data read on edge t is driven right after edge t.
- R7: After an edge that performs a write, `q_drive` is low for the next cycle, whatever `oe_n` is.
- R8: `q_drive` is high only while `oe_n` is low and the current output slot holds a selected read, and `oe_n` acts without a clock edge. A start with the chip not selected (`cs0_n` high, `cs1` low or `cs2_n` high) ends the burst, and nothing is driven from it. `q_out` is zero whenever `q_drive` is low.
- R9: On a cycle with no start, `adv_n` low moves to the next burst address and `adv_n` high repeats the current one. The low two address bits follow start XOR k when `burst_xor` is 1, and start + k modulo 4 when it is 0. The upper bits stay fixed.
- R10: A read after a write returns the written bytes, and the bytes that were not written keep their old values.
- R11: After reset, `q_drive` is low and no burst is active.
- R12: A high `cs0_n` blocks the processor strobe, so that cycle acts as a plain continue or suspend cycle. It does not block the controller strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 8 | External word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs0_n | input | 1 | Master chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write enable, active low |
| bwe_n | input | 1 | Byte-write gate, active low |
| bw_n | input | 2 | Per-byte write enables, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_n | input | 1 | Static: low selects flow-through, high selects pipelined |
| burst_xor | input | 1 | Static: 1 selects interleaved order, 0 selects linear order |
| d_in | input | 16 | Write data |
| q_out | output | 16 | Read data, zero when not driven |
| q_drive | output | 1 | Bus drive enable for tri-state pads |

## Verification
The bound checker watches, on every cycle, the relations that depend only on the pins and a few cycles of history. A controller-strobe write blanks the bus on the next cycle. A selected processor-strobe read in flow-through mode is visible on the next cycle when the output enable allows it. A deselect turns the bus off within the latency of the chosen mode. Stored contents can only be shown by the directed scenarios: the byte merging, the global-write override, the write enables ignored on the load edge, the interleaved and linear burst orders with wrap and suspend, and the master select blocking one strobe but not the other.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    // Number of address bits that a burst walks through (four-word burst).
    localparam int BURST_W = 2;

    // Offset of burst step 'k' from start offset 'start' in XOR or linear order.
    function automatic logic [BURST_W-1:0] burst_off(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] k,
        input logic               xor_mode
    );
        logic [BURST_W-1:0] sum;
        sum = start + k;
        return xor_mode ? (start ^ k) : sum;
    endfunction
endpackage

// File: rtl/bsram_burst_seq.sv
// Burst sequencer: decodes the two address strobes and chip selects, holds
// the base address and the burst step, and presents the address that the
// current edge accesses. Assumes AW is larger than the burst width.
module bsram_burst_seq
    import bsram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          burst_xor,
    output logic          acc_valid,
    output logic [AW-1:0] acc_addr,
    output logic          adsp_ld
);
    logic               active;
    logic [AW-1:0]      base;
    logic [BURST_W-1:0] step_q;
    logic [BURST_W-1:0] step_now;
    logic               adsc_ld;
    logic               load;
    logic               sel;

    // Start decode: master select gates only the processor strobe.
    always_comb begin
        adsp_ld  = !adsp_n && !cs0_n;
        adsc_ld  = !adsc_n && !adsp_ld;
        load     = adsp_ld || adsc_ld;
        sel      = !cs0_n && cs1 && !cs2_n;
        step_now = (!adv_n) ? step_q + 1'b1 : step_q;
    end

    // Address used on this edge: external on a start, else the burst position.
    always_comb begin
        if (load) begin
            acc_addr  = addr;
            acc_valid = sel;
        end else begin
            acc_addr  = {base[AW-1:BURST_W],
                         burst_off(base[BURST_W-1:0], step_now, burst_xor)};
            acc_valid = active;
        end
    end

    // Burst state: a start loads or ends the burst, advance bumps the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= '0;
            step_q <= '0;
        end else if (load) begin
            active <= sel;
            base   <= addr;
            step_q <= '0;
        end else if (active && !adv_n) begin
            step_q <= step_q + 1'b1;
        end
    end
endmodule

// File: rtl/bsram_wr_decode.sv
// Write decode: turns the global write, byte-write gate and per-byte enables
// into one write strobe per byte. Assumes byte i is bit i of bw_n. Writes are
// masked on an edge that is not an access or that starts a processor burst.
module bsram_wr_decode #(
    parameter int NB = 2
) (
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          acc_valid,
    input  logic          adsp_ld,
    output logic [NB-1:0] we,
    output logic          is_wr
);
    for (genvar g = 0; g < NB; g++) begin : g_byte
        // One byte's strobe: global override, or gate plus own enable.
        always_comb begin
            we[g] = acc_valid && !adsp_ld && (!gw_n || (!bwe_n && !bw_n[g]));
        end
    end

    // Any byte written makes the whole cycle a write.
    always_comb begin
        is_wr = |we;
    end
endmodule

// File: rtl/bsram_array.sv
// Storage and read path: one bank per byte, an access register, and an
// output register used only in pipelined mode. Assumes DEPTH is a power of
// two. The bus is driven only for a read, never right after a write.
module bsram_array #(
    parameter int NB    = 2,
    parameter int BW    = 8,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] acc_addr,
    input  logic [NB-1:0] we,
    input  logic          rd_now,
    input  logic          is_wr,
    input  logic [DW-1:0] d_in,
    input  logic          flow_n,
    input  logic          oe_n,
    output logic [DW-1:0] q_out,
    output logic          q_drive
);
    logic [AW-1:0] acc_q;
    logic          rd_q;
    logic          wr_q;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] pipe_q;
    logic          pipe_rd;
    logic [DW-1:0] sel_data;
    logic          sel_valid;

    for (genvar g = 0; g < NB; g++) begin : g_bank
        logic [BW-1:0] bank [DEPTH];

        // Byte bank write on its own strobe.
        always_ff @(posedge clk) begin
            if (we[g]) begin
                bank[acc_addr] <= d_in[g*BW +: BW];
            end
        end

        assign rd_word[g*BW +: BW] = bank[acc_q];
    end

    // Access register: address and kind of the last edge's access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            rd_q  <= 1'b0;
            wr_q  <= 1'b0;
        end else begin
            acc_q <= acc_addr;
            rd_q  <= rd_now;
            wr_q  <= is_wr;
        end
    end

    // Output register stage for pipelined timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q  <= '0;
            pipe_rd <= 1'b0;
        end else begin
            pipe_q  <= rd_word;
            pipe_rd <= rd_q;
        end
    end

    // Mode select and asynchronous output gating.
    always_comb begin
        sel_data  = flow_n ? pipe_q  : rd_word;
        sel_valid = flow_n ? pipe_rd : rd_q;
        q_drive   = !oe_n && sel_valid && !wr_q;
        q_out     = q_drive ? sel_data : '0;
    end
endmodule

// File: rtl/bw_sync_sram.sv
// Top: byte-write synchronous SRAM with a four-word burst sequencer and a
// choice of pipelined or flow-through read timing. flow_n and burst_xor are
// expected to be static during a burst.
module bw_sync_sram #(
    parameter int NB    = 2,
    parameter int BW    = 8,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int DW    = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          adsp_n,
    input  logic          adsc_n,
    input  logic          adv_n,
    input  logic          cs0_n,
    input  logic          cs1,
    input  logic          cs2_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          oe_n,
    input  logic          flow_n,
    input  logic          burst_xor,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] q_out,
    output logic          q_drive
);
    logic          acc_valid;
    logic [AW-1:0] acc_addr;
    logic          adsp_ld;
    logic [NB-1:0] we;
    logic          is_wr;
    logic          rd_now;

    bsram_burst_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .adsp_n    (adsp_n),
        .adsc_n    (adsc_n),
        .adv_n     (adv_n),
        .cs0_n     (cs0_n),
        .cs1       (cs1),
        .cs2_n     (cs2_n),
        .burst_xor (burst_xor),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .adsp_ld   (adsp_ld)
    );

    bsram_wr_decode #(.NB(NB)) u_dec (
        .gw_n      (gw_n),
        .bwe_n     (bwe_n),
        .bw_n      (bw_n),
        .acc_valid (acc_valid),
        .adsp_ld   (adsp_ld),
        .we        (we),
        .is_wr     (is_wr)
    );

    // A selected access that writes nothing is a read.
    always_comb begin
        rd_now = acc_valid && !is_wr;
    end

    bsram_array #(.NB(NB), .BW(BW), .DEPTH(DEPTH), .AW(AW), .DW(DW)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_addr (acc_addr),
        .we       (we),
        .rd_now   (rd_now),
        .is_wr    (is_wr),
        .d_in     (d_in),
        .flow_n   (flow_n),
        .oe_n     (oe_n),
        .q_out    (q_out),
        .q_drive  (q_drive)
    );
endmodule

// File: rtl/bsram_chk.sv
// Pin-level checker for bw_sync_sram: output blanking after writes and
// deselects, and flow-through read visibility.
module bsram_chk (
    input logic clk,
    input logic rst_n,
    input logic adsp_n,
    input logic adsc_n,
    input logic cs0_n,
    input logic cs1,
    input logic cs2_n,
    input logic gw_n,
    input logic oe_n,
    input logic flow_n,
    input logic q_drive
);
    logic       sel;
    logic       p_start;
    logic       c_start;
    logic [1:0] since_rst;

    // Start decode from the pins.
    always_comb begin
        sel     = !cs0_n && cs1 && !cs2_n;
        p_start = !adsp_n && !cs0_n;
        c_start = !adsc_n && !p_start;
    end

    // Saturating count of edges since reset, bounding history lookups.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R7
    wr_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_start && sel && !gw_n) |=> !q_drive);

    // R6
    flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p_start && sel && !flow_n) |=> (oe_n || q_drive));

    // R8
    flow_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_start && !sel && !flow_n) |=> !q_drive);

    // R5
    pipe_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && flow_n && $past(c_start && !sel, 2)
         && $past(adsp_n && adsc_n, 1)) |-> !q_drive);
endmodule

bind bw_sync_sram bsram_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .cs0_n   (cs0_n),
    .cs1     (cs1),
    .cs2_n   (cs2_n),
    .gw_n    (gw_n),
    .oe_n    (oe_n),
    .flow_n  (flow_n),
    .q_drive (q_drive)
);

// File: tb/bw_sync_sram_test.sv
module bw_sync_sram_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        adsp_n = 1'b1, adsc_n = 1'b1, adv_n = 1'b1;
    logic        cs0_n = 1'b0, cs1 = 1'b1, cs2_n = 1'b0;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [1:0]  bw_n = 2'b11;
    logic        oe_n = 1'b0, flow_n = 1'b0, burst_xor = 1'b1;
    logic [15:0] d_in = '0;
    logic [15:0] q_out;
    logic        q_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bw_sync_sram uut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req, input logic [15:0] exp);
        chk(q_drive === 1'b1 && q_out === exp, req, q_drive ? q_out : 16'hzzzz, exp);
    endtask

    task automatic chk_off(input string req);
        chk(q_drive === 1'b0 && q_out === 16'h0, req, {15'd0, q_drive}, 16'h0);
    endtask

    // Set up one cycle's inputs (called at a falling edge) and pass one edge.
    task automatic cyc(input bit sp, input bit sc, input bit av, input bit gw,
                       input bit be, input logic [1:0] b, input logic [7:0] a,
                       input logic [15:0] d);
        adsp_n = sp; adsc_n = sc; adv_n = av; gw_n = gw; bwe_n = be;
        bw_n = b; addr = a; d_in = d;
        tick();
    endtask

    task automatic c_write(input logic [7:0] a, input bit gw, input bit be,
                           input logic [1:0] b, input logic [15:0] d);
        cyc(1, 0, 1, gw, be, b, a, d);
    endtask

    task automatic c_read(input logic [7:0] a);
        cyc(1, 0, 1, 1, 1, 2'b11, a, 16'h0);
    endtask

    task automatic hold(input bit av);
        cyc(1, 1, av, 1, 1, 2'b11, 8'h00, 16'h0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        chk_off("R11 drive low in reset");
        rst_n = 1'b1;
        hold(1);
        chk_off("R11 no burst after reset");
    endtask

    task automatic t_global();
        c_write(8'h10, 0, 0, 2'b11, 16'hA5C3);
        chk_off("R7 flow write blanks bus");
        c_read(8'h10);
        chk_rd("R1 R4 R6 global write read back", 16'hA5C3);
    endtask

    task automatic t_bytes();
        c_write(8'h20, 0, 1, 2'b11, 16'h1111);
        c_write(8'h20, 1, 0, 2'b10, 16'hAABB);
        c_read(8'h20);
        chk_rd("R2 R10 byte0 only", 16'h11BB);
        c_write(8'h20, 1, 1, 2'b00, 16'h0000);
        chk_rd("R2 gate high makes read", 16'h11BB);
        c_write(8'h20, 1, 0, 2'b01, 16'hCC00);
        c_read(8'h20);
        chk_rd("R2 R10 byte1 only", 16'hCCBB);
    endtask

    task automatic t_adsp();
        cyc(0, 1, 1, 0, 0, 2'b00, 8'h20, 16'hFFFF);
        chk_rd("R3 load edge ignores writes", 16'hCCBB);
        cyc(1, 1, 1, 1, 0, 2'b10, 8'h00, 16'h0055);
        chk_off("R7 later edge write blanks");
        c_read(8'h20);
        chk_rd("R3 later edge byte honoured", 16'hCC55);
    endtask

    task automatic t_pipe();
        flow_n = 1'b1;
        cs1 = 1'b0; c_read(8'h00); cs1 = 1'b1;
        hold(1);
        c_read(8'h10);
        chk_off("R5 not yet after access edge");
        hold(1);
        chk_rd("R5 data one cycle later", 16'hA5C3);
        c_write(8'h30, 0, 1, 2'b11, 16'h1234);
        chk_off("R7 pipelined write blanks bus");
        c_read(8'h30);
        hold(1);
        chk_rd("R5 R10 pipelined read of write", 16'h1234);
        flow_n = 1'b0;
        hold(1);
    endtask

    task automatic t_burst();
        for (int i = 0; i < 4; i++)
            c_write(8'h40 + 8'(i), 0, 1, 2'b11, 16'h4000 + 16'(i));
        burst_xor = 1'b1;
        cyc(0, 1, 1, 1, 1, 2'b11, 8'h41, 16'h0);
        chk_rd("R9 xor start", 16'h4001);
        hold(0); chk_rd("R9 xor step1", 16'h4000);
        hold(0); chk_rd("R9 xor step2", 16'h4003);
        hold(1); chk_rd("R9 suspend repeats", 16'h4003);
        hold(0); chk_rd("R9 xor step3", 16'h4002);
        burst_xor = 1'b0;
        cyc(0, 1, 1, 1, 1, 2'b11, 8'h42, 16'h0);
        chk_rd("R9 linear start", 16'h4002);
        hold(0); chk_rd("R9 linear step1", 16'h4003);
        hold(0); chk_rd("R9 linear wrap", 16'h4000);
        hold(0); chk_rd("R9 linear step3", 16'h4001);
        c_write(8'h45, 0, 1, 2'b11, 16'h5005);
        cyc(1, 1, 0, 0, 1, 2'b11, 8'h00, 16'h5006);
        cyc(1, 1, 0, 0, 1, 2'b11, 8'h00, 16'h5007);
        cyc(1, 1, 0, 0, 1, 2'b11, 8'h00, 16'h5004);
        c_read(8'h44);
        chk_rd("R9 write burst wrapped", 16'h5004);
        c_read(8'h47);
        chk_rd("R9 write burst step", 16'h5007);
        burst_xor = 1'b1;
    endtask

    task automatic t_select();
        cyc(0, 1, 1, 1, 1, 2'b11, 8'h41, 16'h0);
        chk_rd("R12 burst start", 16'h4001);
        cs0_n = 1'b1;
        cyc(0, 1, 1, 1, 1, 2'b11, 8'h99, 16'h0);
        chk_rd("R12 blocked strobe acts as suspend", 16'h4001);
        c_read(8'h10);
        chk_off("R8 R12 controller strobe deselects");
        cyc(0, 1, 1, 1, 1, 2'b11, 8'h10, 16'h0);
        chk_off("R12 blocked strobe no start");
        cs0_n = 1'b0;
        oe_n = 1'b1;
        c_read(8'h10);
        chk_off("R8 oe high no drive");
        oe_n = 1'b0;
        #1;
        chk_rd("R8 oe acts without edge", 16'hA5C3);
        cs2_n = 1'b1;
        c_read(8'h10);
        cs2_n = 1'b0;
        chk_off("R8 deselect high-Z");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_global();
        t_bytes();
        t_adsp();
        t_pipe();
        t_burst();
        t_select();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule